// File: doc/BRIEF.md
# Multi-Channel Programmable Baud Rate Generator

This block is a bank of independent clock-enable generators, one for each serial channel. Each generator derives a periodic single-cycle tick from the shared engine clock. The tick is meant to serve as the 1x, 8x, 16x or 32x sampling clock of an attached serial controller, so software programs a tick rate equal to the bit rate times the controller's oversampling factor. Every generator also drives a square-wave version of its tick.

Each generator divides in three stages. A fixed half-rate stage comes first. An optional divide-by-16 prescaler follows, for ratios too large for the divisor field. A programmable counter divides by N last, and N is stored as N-1. The channels are numbered 1 to 16. Software writes and reads their 32-bit configuration words over a plain register bus that carries a write strobe, a channel index and the data. The bus has no flow control, so a write is taken in the cycle its strobe is high.

Without the prescaler the hardware needs an even ratio. A write that asks for an odd ratio in that mode still takes effect, but it sets a sticky error flag for that channel.

Top module: `brg_bank`

## Requirements
- R1: After reset every tick, square-wave and error output is 0, and every channel reads back 0.
- R2: The configuration word has the enable at bit 16, the divisor field (ratio minus 1, 12 bits) at bits [12:1] and the prescaler select at bit 0. A read returns the last word written to that channel, with every other bit read as 0.
- R3: A running channel emits single-cycle ticks spaced exactly 2 x P x (field+1) clock cycles apart, where P is 16 when the prescaler select is 1 and 1 otherwise.
- R4: A write with the enable at 0 stops the channel at once. From the next cycle its tick and square wave stay at 0 until the channel is enabled again.
- R5: A write that turns a stopped channel on restarts its counters from zero. The first tick comes exactly one full period after the clock edge that took the write.
- R6: A write to a running channel that keeps it enabled does not disturb the period in progress. The new ratio and prescaler apply from the tick that ends that period.
- R7: The square wave rises in the same cycle as each tick. For a ratio R of 2 or more it stays high for ceil(R/2) x 2 x P cycles. For a ratio of 1 it toggles at every tick.
- R8: A write with the prescaler select at 0 and an even field value (an odd ratio) sets error bit ch-1. The bit stays set until reset, and later writes neither set nor clear the error bits of other channels.
- R9: A write to channel index 0 or to an index above 16 changes no channel and no error bit. A read of such an index returns 0.
- R10: Channels run independently. Writing one channel does not change the tick spacing of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Channel index of the write, 1 to 16 |
| wr_data | input | 32 | Configuration word to write |
| rd_idx | input | 5 | Channel index to read, 1 to 16 |
| rd_data | output | 32 | Configuration word of channel rd_idx (combinational) |
| tick | output | 16 | Single-cycle tick per channel (bit ch-1) |
| sq_clk | output | 16 | Square-wave clock per channel (bit ch-1) |
| odd_err | output | 16 | Sticky odd-ratio error per channel (bit ch-1) |

## Verification
The bench goes after four corner cases:

- **Reprogramming a running channel.** A design that reloaded the divisor at the moment of the write would cut short the period in progress, or emit a runt tick. The bench measures that period and the one after it.
- **Restarting from the stopped state.** A counter left with stale state would make the first tick early or late, so the bench times the first tick after enabling.
- **The divide-by-16 path and ratios of 1 and 2.** An off-by-one in the prescaler limit or in the N-1 encoding would shift every spacing measured there.
- **Error flag and index decode.** An error flag that cleared on a later good write, or a decode that wrapped index 17 onto channel 1, would show up in the error vector and in readback.

// File: rtl/brg_pkg.sv
package brg_pkg;

  localparam int REG_W   = 32;
  localparam int DIV_W   = 12;
  localparam int EN_POS  = 16;
  localparam int DIV_LSB = 1;
  localparam int PRE_POS = 0;

  typedef struct packed {
    logic             en;
    logic             pre16;
    logic [DIV_W-1:0] div_m1;
  } brg_cfg_t;

  function automatic brg_cfg_t cfg_decode(input logic [REG_W-1:0] w);
    brg_cfg_t c;
    c.en     = w[EN_POS];
    c.pre16  = w[PRE_POS];
    c.div_m1 = w[DIV_LSB +: DIV_W];
    return c;
  endfunction

  function automatic logic [REG_W-1:0] cfg_encode(input brg_cfg_t c);
    logic [REG_W-1:0] w;
    w                   = '0;
    w[EN_POS]           = c.en;
    w[PRE_POS]          = c.pre16;
    w[DIV_LSB +: DIV_W] = c.div_m1;
    return w;
  endfunction

  // odd ratio (field even) is illegal without the prescaler
  function automatic logic cfg_ratio_odd(input brg_cfg_t c);
    return !c.pre16 && !c.div_m1[0];
  endfunction

endpackage

// File: rtl/brg_regbank.sv
module brg_regbank
  import brg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [REG_W-1:0]  rd_data,
  output brg_cfg_t          cfg_wr,
  output brg_cfg_t          cfg_q [NUM_CH],
  output logic [NUM_CH-1:0] wr_hit,
  output logic [NUM_CH-1:0] odd_err
);

  assign cfg_wr = cfg_decode(wr_data);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g + 1);

    assign wr_hit[g] = wr_en && (wr_idx == MY_IDX);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_q[g]   <= '0;
        odd_err[g] <= 1'b0;
      end else if (wr_hit[g]) begin
        cfg_q[g] <= cfg_wr;
        if (cfg_ratio_odd(cfg_wr)) odd_err[g] <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (rd_idx == IDX_W'(i + 1)) rd_data = cfg_encode(cfg_q[i]);
    end
  end

endmodule

// File: rtl/brg_prescale.sv
module brg_prescale #(
  parameter int HALF_DIV = 2,
  parameter int PRE_DIV  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  input  logic pre16,
  output logic pulse
);

  localparam int SPAN = HALF_DIV * PRE_DIV;
  localparam int CW   = $clog2(SPAN);
  localparam logic [CW-1:0] LIM_LO = CW'(HALF_DIV - 1);
  localparam logic [CW-1:0] LIM_HI = CW'(SPAN - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim   = pre16 ? LIM_HI : LIM_LO;
  assign pulse = run && !clr && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || !run)  cnt <= '0;
    else if (cnt == lim)   cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end

endmodule

// File: rtl/brg_channel.sv
module brg_channel
  import brg_pkg::*;
#(
  parameter int HALF_DIV = 2,
  parameter int PRE_DIV  = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_hit,
  input  brg_cfg_t cfg_wr,
  input  brg_cfg_t cfg_q,
  output logic     tick,
  output logic     sq_clk
);

  brg_cfg_t         act;
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] mid;
  logic             stop;
  logic             restart;
  logic             pulse;
  logic             term;

  assign stop    = wr_hit && !cfg_wr.en;
  assign restart = wr_hit && cfg_wr.en && !act.en;
  assign mid     = act.div_m1 >> 1;
  assign term    = pulse && (cnt == act.div_m1);

  brg_prescale #(
    .HALF_DIV (HALF_DIV),
    .PRE_DIV  (PRE_DIV)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (stop || restart),
    .run   (act.en),
    .pre16 (act.pre16),
    .pulse (pulse)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act    <= '0;
      cnt    <= '0;
      tick   <= 1'b0;
      sq_clk <= 1'b0;
    end else begin
      tick <= 1'b0;
      if (stop || restart) begin
        act    <= cfg_wr;
        cnt    <= '0;
        sq_clk <= 1'b0;
      end else if (term) begin
        // period boundary: pick up any pending configuration
        tick   <= 1'b1;
        cnt    <= '0;
        act    <= cfg_q;
        sq_clk <= (act.div_m1 == '0) ? !sq_clk : 1'b1;
      end else if (pulse) begin
        cnt <= cnt + 1'b1;
        if (cnt == mid) sq_clk <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/brg_bank.sv
module brg_bank
  import brg_pkg::*;
#(
  parameter int NUM_CH   = 16,
  parameter int HALF_DIV = 2,
  parameter int PRE_DIV  = 16,
  parameter int IDX_W    = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [REG_W-1:0]  wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [REG_W-1:0]  rd_data,
  output logic [NUM_CH-1:0] tick,
  output logic [NUM_CH-1:0] sq_clk,
  output logic [NUM_CH-1:0] odd_err
);

  brg_cfg_t          cfg_wr;
  brg_cfg_t          cfg_q [NUM_CH];
  logic [NUM_CH-1:0] wr_hit;

  brg_regbank #(
    .NUM_CH (NUM_CH),
    .IDX_W  (IDX_W)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .cfg_wr  (cfg_wr),
    .cfg_q   (cfg_q),
    .wr_hit  (wr_hit),
    .odd_err (odd_err)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    brg_channel #(
      .HALF_DIV (HALF_DIV),
      .PRE_DIV  (PRE_DIV)
    ) u_ch (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (wr_hit[g]),
      .cfg_wr (cfg_wr),
      .cfg_q  (cfg_q[g]),
      .tick   (tick[g]),
      .sq_clk (sq_clk[g])
    );
  end

endmodule

// File: rtl/brg_bank_chk.sv
module brg_bank_chk
  import brg_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [REG_W-1:0]  wr_data,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [REG_W-1:0]  rd_data,
  input logic [NUM_CH-1:0] tick,
  input logic [NUM_CH-1:0] sq_clk,
  input logic [NUM_CH-1:0] odd_err
);

  localparam logic [REG_W-1:0] USED =
    (REG_W'(1) << EN_POS) | (REG_W'(1) << PRE_POS) |
    (((REG_W'(1) << DIV_W) - 1) << DIV_LSB);

  logic bad_wr;
  logic bad_rd;
  assign bad_wr = wr_en && ((wr_idx == '0) || (wr_idx > IDX_W'(NUM_CH)));
  assign bad_rd = (rd_idx == '0) || (rd_idx > IDX_W'(NUM_CH));

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~USED) == '0); // R2

  AST_BAD_IDX_WR: assert property (@(posedge clk) disable iff (!rst_n)
    bad_wr |=> $stable(odd_err)); // R9

  AST_BAD_IDX_RD: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rd |-> rd_data == '0); // R9

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g + 1);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick[g] |=> !tick[g]); // R3

    AST_STOP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == MY_IDX && !wr_data[EN_POS]) |=> (!tick[g] && !sq_clk[g])); // R4

    AST_SQ_RISE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sq_clk[g]) |-> tick[g]); // R7

    AST_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == MY_IDX && !wr_data[PRE_POS] && !wr_data[DIV_LSB]) |=> odd_err[g]); // R8

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      odd_err[g] |=> odd_err[g]); // R8
  end

endmodule

bind brg_bank brg_bank_chk #(
  .NUM_CH (NUM_CH),
  .IDX_W  (IDX_W)
) u_brg_bank_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_data (wr_data),
  .rd_idx  (rd_idx),
  .rd_data (rd_data),
  .tick    (tick),
  .sq_clk  (sq_clk),
  .odd_err (odd_err)
);

// File: tb/test_brg_bank.sv
`timescale 1ns/1ps
module test_brg_bank;

  localparam int NUM_CH = 16;
  localparam int IDX_W  = 5;
  localparam int WD_LIMIT = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [31:0]       wr_data = '0;
  logic [IDX_W-1:0]  rd_idx = '0;
  logic [31:0]       rd_data;
  logic [NUM_CH-1:0] tick;
  logic [NUM_CH-1:0] sq_clk;
  logic [NUM_CH-1:0] odd_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  brg_bank i_brg_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data),
    .tick    (tick),
    .sq_clk  (sq_clk),
    .odd_err (odd_err)
  );

  function automatic int exp_period(input bit pre, input int f);
    return 2 * (pre ? 16 : 1) * (f + 1);
  endfunction

  function automatic int exp_high(input bit pre, input int f);
    return 2 * (pre ? 16 : 1) * ((f >> 1) + 1);
  endfunction

  function automatic logic [31:0] exp_word(input bit en, input bit pre, input int f);
    return (32'(en) << 16) | (32'(f & 12'hFFF) << 1) | 32'(pre);
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input bit en, input bit pre, input int f, input logic [31:0] junk);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_idx  = IDX_W'(idx);
    wr_data = exp_word(en, pre, f) | (junk & ~32'h0001_1FFF);
    @(negedge clk);
    wr_en   = 1'b0;
  endtask

  task automatic wait_tick(input int ch, output int t);
    int guard;
    guard = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      guard++;
    end while (!tick[ch-1] && guard < 5000);
    t = tick[ch-1] ? cyc : -1;
  endtask

  // restart a channel, check first-tick latency and spacing
  task automatic run_case(input int ch, input bit pre, input int f, input string tag);
    int t0, t1, t2;
    wr(ch, 0, 0, 1, 32'h0);
    wr(ch, 1, pre, f, 32'h0);
    t0 = cyc;
    wait_tick(ch, t1);
    chk(t1 - t0 == exp_period(pre, f), {tag, " R5 first tick"}, t1 - t0, exp_period(pre, f));
    @(posedge clk); @(negedge clk);
    chk(tick[ch-1] == 1'b0, {tag, " R3 single cycle"}, tick[ch-1], 0);
    wait_tick(ch, t2);
    chk(t2 - t1 == exp_period(pre, f), {tag, " R3 spacing"}, t2 - t1, exp_period(pre, f));
  endtask

  initial begin
    wait (cyc == WD_LIMIT);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cyc, WD_LIMIT);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t1, t2, t3, n;
    void'($urandom(32'h5EED_0B2C));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(tick == '0, "R1 tick", tick, 0);
    chk(sq_clk == '0, "R1 sq_clk", sq_clk, 0);
    chk(odd_err == '0, "R1 odd_err", odd_err, 0);
    rd_idx = 5'd9; #1;
    chk(rd_data == 32'h0, "R1 readback", rd_data, 0);

    // R2 layout and readback, junk in unused bits
    wr(3, 1, 0, 12'h123, 32'hFFFF_FFFF);
    rd_idx = 5'd3; #1;
    chk(rd_data == exp_word(1, 0, 12'h123), "R2 readback", rd_data, exp_word(1, 0, 12'h123));
    wr(3, 0, 1, 12'hABD, 32'hA5A5_0000);
    #1;
    chk(rd_data == exp_word(0, 1, 12'hABD), "R2 readback2", rd_data, exp_word(0, 1, 12'hABD));

    // R3/R5 directed ratios including 2 and the prescaler path
    run_case(1, 0, 1, "ch1");
    run_case(2, 1, 0, "ch2");
    run_case(16, 0, 3, "ch16");

    // R7 square wave, even ratio without prescaler
    run_case(5, 0, 5, "ch5");
    wait_tick(5, t1);
    chk(sq_clk[4] == 1'b1, "R7 rise with tick", sq_clk[4], 1);
    n = 0;
    while (sq_clk[4] && n < 5000) begin @(posedge clk); @(negedge clk); n++; end
    chk(n == exp_high(0, 5), "R7 high time", n, exp_high(0, 5));
    // R7 odd ratio with prescaler
    run_case(5, 1, 2, "ch5p");
    wait_tick(5, t1);
    n = 0;
    while (sq_clk[4] && n < 5000) begin @(posedge clk); @(negedge clk); n++; end
    chk(n == exp_high(1, 2), "R7 high time pre", n, exp_high(1, 2));
    wr(5, 0, 0, 1, 32'h0);

    // R6 reprogram a running channel
    run_case(4, 0, 7, "ch4");
    wait_tick(4, t1);
    wr(4, 1, 0, 1, 32'h0);
    wait_tick(4, t2);
    wait_tick(4, t3);
    chk(t2 - t1 == exp_period(0, 7), "R6 old period kept", t2 - t1, exp_period(0, 7));
    chk(t3 - t2 == exp_period(0, 1), "R6 new period", t3 - t2, exp_period(0, 1));

    // R10 independence: ch9 spacing while ch4 is stopped and ch8 rewritten
    run_case(9, 0, 5, "ch9");
    wait_tick(9, t1);
    wr(4, 0, 0, 1, 32'h0);
    wr(8, 1, 0, 3, 32'h0);
    wait_tick(9, t2);
    chk(t2 - t1 == exp_period(0, 5), "R10 ch9 undisturbed", t2 - t1, exp_period(0, 5));
    wr(8, 0, 0, 1, 32'h0);
    wr(9, 0, 0, 1, 32'h0);

    // R4 stop: ch1 still running at ratio 2
    wr(1, 0, 0, 1, 32'h0);
    n = 0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); @(negedge clk);
      if (tick[0] || sq_clk[0]) n++;
    end
    chk(n == 0, "R4 no activity after stop", n, 0);
    wr(2, 0, 0, 1, 32'h0);
    wr(16, 0, 0, 1, 32'h0);

    // R8 sticky odd-ratio error
    wr(6, 0, 0, 4, 32'h0);
    chk(odd_err == 16'h0020, "R8 set", odd_err, 16'h0020);
    wr(6, 0, 0, 5, 32'h0);
    chk(odd_err == 16'h0020, "R8 sticky", odd_err, 16'h0020);
    wr(7, 0, 1, 4, 32'h0);
    chk(odd_err == 16'h0020, "R8 prescaler exempt", odd_err, 16'h0020);

    // R9 out of range indices
    rd_idx = 5'd1; #1;
    t1 = rd_data;
    wr(0, 1, 0, 2, 32'h0);
    wr(17, 1, 0, 2, 32'h0);
    chk(odd_err == 16'h0020, "R9 writes ignored", odd_err, 16'h0020);
    rd_idx = 5'd1; #1;
    chk(rd_data == 32'(t1), "R9 no alias onto ch1", rd_data, t1);
    rd_idx = 5'd17; #1;
    chk(rd_data == 32'h0, "R9 read 17", rd_data, 0);
    rd_idx = 5'd0; #1;
    chk(rd_data == 32'h0, "R9 read 0", rd_data, 0);
    for (int k = 0; k < 80; k++) begin
      @(posedge clk); @(negedge clk);
      if (tick != '0) n++;
    end
    chk(n == 0, "R9 no channel started", n, 0);

    // random even ratios and prescaler settings
    for (int it = 0; it < 10; it++) begin
      int ch;
      bit pre;
      int f;
      ch  = 1 + int'($urandom % 16);
      pre = bit'($urandom % 2);
      f   = pre ? int'($urandom % 4) : (int'($urandom % 16) | 1);
      run_case(ch, pre, f, $sformatf("rnd%0d", it));
      rd_idx = IDX_W'(ch); #1;
      chk(rd_data == exp_word(1, pre, f), "R2 random readback", rd_data, exp_word(1, pre, f));
      wr(ch, 0, 0, 1, 32'h0);
    end
    chk(odd_err == 16'h0020, "R8 final error vector", odd_err, 16'h0020);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule